// File: doc/BRIEF.md
# Local Interrupt Pending Selector

This block decides which local interrupt a processor core must take next. It holds four bit vectors of `NIRQ` bits each: the pending interrupts, the enabled interrupts, a delegation mask that hands chosen interrupts to the supervisor level, and a claim mask. An interrupt source can reserve bits in the claim mask once, and a later reservation that touches the same bits is refused. The selector takes these vectors together with the current privilege level and the two global enable bits. It reports whether an interrupt must be taken, and if so gives its number.

The pending vector is updated through a mask-and-value port. Bits under the mask take the new value and all other bits keep their state. The value the vector held before each write is captured so that the writer can read it back. An interrupt is a candidate only when it is both pending and enabled. Candidates that are not delegated are allowed by the machine-level enable, and delegated candidates by the supervisor-level enable. When several candidates survive, the lowest index wins. The result is registered, so it follows the state and the inputs with one cycle of latency.

Top module: `intr_select`

## Requirements
- R1: While `rst_n` is low (sampled on a rising edge), the pending, enable, delegation, claim and previous-value registers clear to zero, and `irq_valid` and `irq_cause` read 0 after that edge.
- R2: Only bits that are set in both the pending vector and the enable vector can be selected. A pending bit that is not enabled is never reported.
- R3: A non-delegated candidate (its delegation bit 0) is allowed when the privilege is below machine, or when the privilege is machine and `m_gie` is 1.
- R4: A delegated candidate (its delegation bit 1) is allowed when the privilege is user, or when it is supervisor and `s_gie` is 1. At machine privilege it is never allowed.
- R5: When several allowed candidates exist, `irq_cause` gives the binary index of the lowest-numbered one and `irq_valid` is 1.
- R6: When no candidate is allowed, `irq_valid` is 0 and `irq_cause` is 0.
- R7: A pending write (`pend_wr_en`=1) sets the pending vector to (old AND NOT `pend_wr_mask`) OR (`pend_wr_val` AND `pend_wr_mask`), visible on `pend_vec` after that edge.
- R8: `pend_prev` takes the pending vector's value from before each write at that write's edge, and holds it while no write happens.
- R9: A claim (`clm_req`=1) whose `clm_bits` share no bit with `claim_mask` adds those bits to `claim_mask` and pulses `clm_ok` for one cycle after the edge.
- R10: A claim whose `clm_bits` overlap `claim_mask` leaves `claim_mask` unchanged and pulses `clm_fail` for one cycle after the edge.
- R11: Privilege encoding on `priv`: 0 is user, 1 is supervisor, 3 is machine, and 2 behaves exactly as user.
- R12: `irq_valid` and `irq_cause` are registered. They reflect `priv`, `m_gie` and `s_gie` as sampled at a rising edge, and the registered vectors as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_wr_en | input | 1 | Pending-vector write strobe |
| pend_wr_mask | input | NIRQ | Bits of the pending vector to replace |
| pend_wr_val | input | NIRQ | New values for the masked bits |
| en_wr_en | input | 1 | Enable-vector write strobe |
| en_wr_val | input | NIRQ | New enable vector |
| dlg_wr_en | input | 1 | Delegation-mask write strobe |
| dlg_wr_val | input | NIRQ | New delegation mask |
| clm_req | input | 1 | Claim request strobe |
| clm_bits | input | NIRQ | Bits to reserve |
| priv | input | 2 | Current privilege level |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| pend_vec | output | NIRQ | Current pending vector |
| pend_prev | output | NIRQ | Pending vector before the latest write |
| claim_mask | output | NIRQ | Bits reserved so far |
| clm_ok | output | 1 | Claim accepted, one-cycle pulse |
| clm_fail | output | 1 | Claim refused, one-cycle pulse |
| irq_valid | output | 1 | An interrupt must be taken |
| irq_cause | output | $clog2(NIRQ) | Index of the chosen interrupt |

## Verification
A corrupted pending or claim register shows up on `pend_vec` or `claim_mask` on the edge after the bad write. A wrong delegation or enable bit shows only through the selection, one edge after the cause of the error: a wrong `irq_cause` index, or `irq_valid` appearing or missing for a given privilege and enable setting. The directed tests therefore set up each privilege level with each global enable, with both delegated and non-delegated candidates. They then compare the registered selection with a model of the gating rules. A fault in the claim logic shows as a wrong pulse on the edge after the request, and a mask that either grows or stays the same when it should not.

// File: rtl/intr_select_pkg.sv
package intr_select_pkg;

    typedef enum logic [1:0] {
        PRIV_USR = 2'd0,
        PRIV_SUP = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_MCH = 2'd3
    } priv_e;

    // machine-level gate: anything below machine, or machine with global enable
    function automatic logic mch_gate(input logic [1:0] p, input logic gie);
        return (p != PRIV_MCH) || gie;
    endfunction

    // supervisor-level gate: user (reserved code folds to user), or supervisor with enable
    function automatic logic sup_gate(input logic [1:0] p, input logic gie);
        return (p == PRIV_USR) || (p == PRIV_RSV) || ((p == PRIV_SUP) && gie);
    endfunction

endpackage

// File: rtl/intr_regs.sv
module intr_regs #(
    parameter int NIRQ = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_we,
    input  logic [NIRQ-1:0] pend_mask,
    input  logic [NIRQ-1:0] pend_val,
    input  logic            en_we,
    input  logic [NIRQ-1:0] en_val,
    input  logic            dlg_we,
    input  logic [NIRQ-1:0] dlg_val,
    output logic [NIRQ-1:0] pend_q,
    output logic [NIRQ-1:0] prev_q,
    output logic [NIRQ-1:0] en_q,
    output logic [NIRQ-1:0] dlg_q
);

    typedef struct packed {
        logic [NIRQ-1:0] pend;
        logic [NIRQ-1:0] prev;
        logic [NIRQ-1:0] en;
        logic [NIRQ-1:0] dlg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (pend_we) begin
            r_d.pend = (r_q.pend & ~pend_mask) | (pend_val & pend_mask);
            r_d.prev = r_q.pend;
        end
        if (en_we) begin
            r_d.en = en_val;
        end
        if (dlg_we) begin
            r_d.dlg = dlg_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend_q = r_q.pend;
    assign prev_q = r_q.prev;
    assign en_q   = r_q.en;
    assign dlg_q  = r_q.dlg;

endmodule

// File: rtl/intr_claim.sv
module intr_claim #(
    parameter int NIRQ = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [NIRQ-1:0] bits,
    output logic [NIRQ-1:0] mask_q,
    output logic            ok_q,
    output logic            fail_q
);

    typedef struct packed {
        logic [NIRQ-1:0] mask;
        logic            ok;
        logic            fail;
    } clm_t;

    clm_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.ok   = 1'b0;
        c_d.fail = 1'b0;
        if (req) begin
            if ((c_q.mask & bits) != '0) begin
                c_d.fail = 1'b1;
            end else begin
                c_d.mask = c_q.mask | bits;
                c_d.ok   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mask_q = c_q.mask;
    assign ok_q   = c_q.ok;
    assign fail_q = c_q.fail;

endmodule

// File: rtl/intr_pick.sv
module intr_pick
    import intr_select_pkg::*;
#(
    parameter int NIRQ = 16,
    localparam int CW  = $clog2(NIRQ)
) (
    input  logic [NIRQ-1:0] pend,
    input  logic [NIRQ-1:0] en,
    input  logic [NIRQ-1:0] dlg,
    input  logic [1:0]      priv,
    input  logic            m_gie,
    input  logic            s_gie,
    output logic            vld,
    output logic [CW-1:0]   cause
);

    logic [NIRQ-1:0] cand;
    logic [NIRQ-1:0] live;
    logic            m_on;
    logic            s_on;

    always_comb begin
        m_on  = mch_gate(priv, m_gie);
        s_on  = sup_gate(priv, s_gie);
        cand  = pend & en;
        live  = (cand & ~dlg & {NIRQ{m_on}}) | (cand & dlg & {NIRQ{s_on}});
        vld   = |live;
        cause = '0;
        // scan from the top so the lowest set bit is written last
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (live[i]) begin
                cause = CW'(i);
            end
        end
    end

endmodule

// File: rtl/intr_select.sv
module intr_select #(
    parameter int NIRQ = 16,
    localparam int CW  = $clog2(NIRQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_wr_en,
    input  logic [NIRQ-1:0] pend_wr_mask,
    input  logic [NIRQ-1:0] pend_wr_val,
    input  logic            en_wr_en,
    input  logic [NIRQ-1:0] en_wr_val,
    input  logic            dlg_wr_en,
    input  logic [NIRQ-1:0] dlg_wr_val,
    input  logic            clm_req,
    input  logic [NIRQ-1:0] clm_bits,
    input  logic [1:0]      priv,
    input  logic            m_gie,
    input  logic            s_gie,
    output logic [NIRQ-1:0] pend_vec,
    output logic [NIRQ-1:0] pend_prev,
    output logic [NIRQ-1:0] claim_mask,
    output logic            clm_ok,
    output logic            clm_fail,
    output logic            irq_valid,
    output logic [CW-1:0]   irq_cause
);

    logic [NIRQ-1:0] en_vec;
    logic [NIRQ-1:0] dlg_vec;
    logic            pick_vld;
    logic [CW-1:0]   pick_cause;

    intr_regs #(.NIRQ(NIRQ)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_we   (pend_wr_en),
        .pend_mask (pend_wr_mask),
        .pend_val  (pend_wr_val),
        .en_we     (en_wr_en),
        .en_val    (en_wr_val),
        .dlg_we    (dlg_wr_en),
        .dlg_val   (dlg_wr_val),
        .pend_q    (pend_vec),
        .prev_q    (pend_prev),
        .en_q      (en_vec),
        .dlg_q     (dlg_vec)
    );

    intr_claim #(.NIRQ(NIRQ)) u_claim (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (clm_req),
        .bits   (clm_bits),
        .mask_q (claim_mask),
        .ok_q   (clm_ok),
        .fail_q (clm_fail)
    );

    intr_pick #(.NIRQ(NIRQ)) u_pick (
        .pend  (pend_vec),
        .en    (en_vec),
        .dlg   (dlg_vec),
        .priv  (priv),
        .m_gie (m_gie),
        .s_gie (s_gie),
        .vld   (pick_vld),
        .cause (pick_cause)
    );

    typedef struct packed {
        logic          vld;
        logic [CW-1:0] cause;
    } sel_t;

    sel_t s_d, s_q;

    always_comb begin
        s_d.vld   = pick_vld;
        s_d.cause = pick_cause;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_valid = s_q.vld;
    assign irq_cause = s_q.cause;

endmodule

// File: rtl/intr_select_chk.sv
module intr_select_chk #(
    parameter int NIRQ = 16,
    localparam int CW  = $clog2(NIRQ)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pend_wr_en,
    input logic [NIRQ-1:0] pend_wr_mask,
    input logic [NIRQ-1:0] pend_wr_val,
    input logic            clm_req,
    input logic [NIRQ-1:0] clm_bits,
    input logic [1:0]      priv,
    input logic            m_gie,
    input logic            s_gie,
    input logic [NIRQ-1:0] pend_vec,
    input logic [NIRQ-1:0] pend_prev,
    input logic [NIRQ-1:0] claim_mask,
    input logic            clm_ok,
    input logic            clm_fail,
    input logic            irq_valid,
    input logic [CW-1:0]   irq_cause,
    input logic [NIRQ-1:0] en_vec,
    input logic [NIRQ-1:0] dlg_vec
);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_valid && pend_vec == '0 && claim_mask == '0));

    p_idle_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> irq_cause == '0);

    p_cand_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ((($past(pend_vec & en_vec) >> irq_cause) & NIRQ'(1)) != '0));

    p_mch_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(priv == 2'd3 && !m_gie) |-> !irq_valid);

    p_sup_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && $past(priv == 2'd1 && !s_gie)) |->
            ((($past(dlg_vec) >> irq_cause) & NIRQ'(1)) == '0));

    p_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr_en |=> pend_vec == $past((pend_vec & ~pend_wr_mask) | (pend_wr_val & pend_wr_mask)));

    p_prev_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr_en |=> pend_prev == $past(pend_vec));

    p_prev_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr_en |=> $stable(pend_prev));

    p_claim_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clm_req && (claim_mask & clm_bits) == '0) |=>
            (clm_ok && !clm_fail && claim_mask == $past(claim_mask | clm_bits)));

    p_claim_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clm_req && (claim_mask & clm_bits) != '0) |=>
            (clm_fail && !clm_ok && $stable(claim_mask)));

endmodule

bind intr_select intr_select_chk #(.NIRQ(NIRQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_wr_en   (pend_wr_en),
    .pend_wr_mask (pend_wr_mask),
    .pend_wr_val  (pend_wr_val),
    .clm_req      (clm_req),
    .clm_bits     (clm_bits),
    .priv         (priv),
    .m_gie        (m_gie),
    .s_gie        (s_gie),
    .pend_vec     (pend_vec),
    .pend_prev    (pend_prev),
    .claim_mask   (claim_mask),
    .clm_ok       (clm_ok),
    .clm_fail     (clm_fail),
    .irq_valid    (irq_valid),
    .irq_cause    (irq_cause),
    .en_vec       (en_vec),
    .dlg_vec      (dlg_vec)
);

// File: tb/test_intr_select.sv
`timescale 1ns/1ps
module test_intr_select;

    localparam int NIRQ = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pend_wr_en = 1'b0;
    logic [15:0] pend_wr_mask = '0;
    logic [15:0] pend_wr_val = '0;
    logic        en_wr_en = 1'b0;
    logic [15:0] en_wr_val = '0;
    logic        dlg_wr_en = 1'b0;
    logic [15:0] dlg_wr_val = '0;
    logic        clm_req = 1'b0;
    logic [15:0] clm_bits = '0;
    logic [1:0]  priv = 2'd0;
    logic        m_gie = 1'b0;
    logic        s_gie = 1'b0;
    logic [15:0] pend_vec, pend_prev, claim_mask;
    logic        clm_ok, clm_fail, irq_valid;
    logic [3:0]  irq_cause;

    int n_chk = 0;
    int n_bad = 0;

    // bench-side copies of what has been written
    logic [15:0] m_pend = '0;
    logic [15:0] m_en = '0;
    logic [15:0] m_dlg = '0;

    always #2.5 clk = ~clk;

    intr_select #(.NIRQ(NIRQ)) i_intr_select (
        .clk(clk), .rst_n(rst_n),
        .pend_wr_en(pend_wr_en), .pend_wr_mask(pend_wr_mask), .pend_wr_val(pend_wr_val),
        .en_wr_en(en_wr_en), .en_wr_val(en_wr_val),
        .dlg_wr_en(dlg_wr_en), .dlg_wr_val(dlg_wr_val),
        .clm_req(clm_req), .clm_bits(clm_bits),
        .priv(priv), .m_gie(m_gie), .s_gie(s_gie),
        .pend_vec(pend_vec), .pend_prev(pend_prev), .claim_mask(claim_mask),
        .clm_ok(clm_ok), .clm_fail(clm_fail),
        .irq_valid(irq_valid), .irq_cause(irq_cause)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // selection model written from the gating rules
    function automatic logic [4:0] model(input logic [15:0] p, e, d,
                                         input logic [1:0] pr, input logic mg, sg);
        logic        mon, son;
        logic [15:0] s;
        logic [4:0]  r;
        mon = (pr != 2'd3) || mg;
        son = (pr == 2'd0) || (pr == 2'd2) || ((pr == 2'd1) && sg);
        s = (p & e & ~d & {16{mon}}) | (p & e & d & {16{son}});
        r = 5'd0;
        for (int i = 15; i >= 0; i--) begin
            if (s[i]) r = {1'b1, 4'(i)};
        end
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_pend(input logic [15:0] mk, input logic [15:0] v);
        @(negedge clk);
        pend_wr_en = 1'b1; pend_wr_mask = mk; pend_wr_val = v;
        step();
        pend_wr_en = 1'b0;
        m_pend = (m_pend & ~mk) | (v & mk);
    endtask

    task automatic cfg(input logic [15:0] e, input logic [15:0] d,
                       input logic [1:0] pr, input logic mg, input logic sg);
        @(negedge clk);
        en_wr_en = 1'b1; en_wr_val = e; dlg_wr_en = 1'b1; dlg_wr_val = d;
        priv = pr; m_gie = mg; s_gie = sg;
        m_en = e; m_dlg = d;
        step();
        en_wr_en = 1'b0; dlg_wr_en = 1'b0;
        step();
    endtask

    task automatic chk_sel(input string tag);
        logic [4:0] ex;
        ex = model(m_pend, m_en, m_dlg, priv, m_gie, s_gie);
        chk({tag, " valid"}, 32'(irq_valid), 32'(ex[4]));
        chk({tag, " cause"}, 32'(irq_cause), 32'(ex[3:0]));
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(irq_valid), 0);
        chk("R1 cause", 32'(irq_cause), 0);
        chk("R1 pend", 32'(pend_vec), 0);
        chk("R1 claim", 32'(claim_mask), 0);
        chk("R1 prev", 32'(pend_prev), 0);
    endtask

    task automatic t_pend_write();
        wr_pend(16'hFFFF, 16'h00F0);
        chk("R7 full write", 32'(pend_vec), 32'h00F0);
        chk("R8 prev after first", 32'(pend_prev), 32'h0000);
        wr_pend(16'h0030, 16'h0000);
        chk("R7 masked clear", 32'(pend_vec), 32'h00C0);
        chk("R8 prev old value", 32'(pend_prev), 32'h00F0);
        wr_pend(16'h0300, 16'hFFFF);
        chk("R7 masked set", 32'(pend_vec), 32'h03C0);
        step();
        chk("R8 prev holds", 32'(pend_prev), 32'h00C0);
    endtask

    task automatic t_enable_gate();
        cfg(16'h0000, 16'h0000, 2'd3, 1'b1, 1'b1);
        chk("R2 none enabled valid", 32'(irq_valid), 0);
        chk("R6 none cause", 32'(irq_cause), 0);
        cfg(16'h0300, 16'h0000, 2'd3, 1'b1, 1'b0);
        chk_sel("R2 enabled subset");
        chk("R2 cause 8", 32'(irq_cause), 8);
    endtask

    task automatic t_machine();
        cfg(16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b1);
        chk("R3 machine gie off", 32'(irq_valid), 0);
        cfg(16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0);
        chk_sel("R3 machine gie on");
        cfg(16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0);
        chk_sel("R3 supervisor below machine");
        chk("R3 cause 6", 32'(irq_cause), 6);
        cfg(16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
        chk_sel("R3 user");
    endtask

    task automatic t_deleg();
        cfg(16'hFFFF, 16'hFFFF, 2'd1, 1'b1, 1'b0);
        chk("R4 sup gie off", 32'(irq_valid), 0);
        cfg(16'hFFFF, 16'hFFFF, 2'd1, 1'b0, 1'b1);
        chk_sel("R4 sup gie on");
        cfg(16'hFFFF, 16'hFFFF, 2'd3, 1'b1, 1'b1);
        chk("R4 machine blocks delegated", 32'(irq_valid), 0);
        cfg(16'hFFFF, 16'hFFFF, 2'd0, 1'b0, 1'b0);
        chk_sel("R4 user allows delegated");
        cfg(16'hFFFF, 16'hFFFF, 2'd2, 1'b0, 1'b0);
        chk_sel("R11 code 2 as user");
        chk("R11 valid", 32'(irq_valid), 1);
        cfg(16'hFFFF, 16'h0000, 2'd2, 1'b0, 1'b0);
        chk("R11 code 2 below machine", 32'(irq_valid), 1);
    endtask

    task automatic t_priority();
        wr_pend(16'hFFFF, 16'h8421);
        cfg(16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0);
        chk("R5 lowest 0", 32'(irq_cause), 0);
        cfg(16'h8420, 16'h0000, 2'd3, 1'b1, 1'b0);
        chk("R5 lowest 5", 32'(irq_cause), 5);
        cfg(16'h8420, 16'h0020, 2'd3, 1'b1, 1'b0);
        chk_sel("R5 mixed delegation");
        chk("R5 skips delegated 5", 32'(irq_cause), 10);
        cfg(16'h8420, 16'h0420, 2'd1, 1'b0, 1'b1);
        chk("R5 sup picks delegated 5", 32'(irq_cause), 5);
    endtask

    task automatic t_registered();
        cfg(16'h8420, 16'h0000, 2'd3, 1'b1, 1'b0);
        chk("R12 before change", 32'(irq_valid), 1);
        @(negedge clk);
        m_gie = 1'b0;
        #1;
        chk("R12 no change before edge", 32'(irq_valid), 1);
        step();
        chk("R12 after edge", 32'(irq_valid), 0);
    endtask

    task automatic t_claim();
        @(negedge clk);
        clm_req = 1'b1; clm_bits = 16'h0003;
        step();
        clm_req = 1'b0;
        chk("R9 ok", 32'(clm_ok), 1);
        chk("R9 mask", 32'(claim_mask), 32'h0003);
        @(negedge clk);
        clm_req = 1'b1; clm_bits = 16'h0006;
        step();
        clm_req = 1'b0;
        chk("R10 fail", 32'(clm_fail), 1);
        chk("R10 no ok", 32'(clm_ok), 0);
        chk("R10 mask unchanged", 32'(claim_mask), 32'h0003);
        @(negedge clk);
        clm_req = 1'b1; clm_bits = 16'h000C;
        step();
        clm_req = 1'b0;
        chk("R9 second ok", 32'(clm_ok), 1);
        chk("R9 mask grows", 32'(claim_mask), 32'h000F);
        step();
        chk("R9 pulse ends", 32'(clm_ok), 0);
        chk("R10 pulse idle", 32'(clm_fail), 0);
    endtask

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_pend_write();
        t_enable_gate();
        t_machine();
        t_deleg();
        t_priority();
        t_registered();
        t_claim();
        finish_run();
    end

endmodule